// File: doc/BRIEF.md
# Swappable Module Context Manager

This block lives in the fixed region of a partially reconfigurable device, wrapped around a single slot that takes one swappable module at a time. All modules that may occupy the slot have the same port list, the union of their ports, and a given module may leave some ports unused. While a module is being replaced, the block keeps two things valid. The first is the internal context the module marked for keeping. The second is the values the slot presents to the surrounding logic.

A reconfiguration controller drives three controls: a presence level, a save strobe and a restore strobe. On a save, shadow registers copy the module's state word. The save is taken only while the slot reports a module present, so the block never captures undefined values from a slot that is half loaded. On a restore, the shadow word is returned to the newly loaded module with a one-cycle load-valid pulse. Each module output passes through its own lane register. The register's enable is the presence level, so it passes values through while the module is present. Once the module is absent, a per-lane parameter bit decides what the lane shows: it either keeps its last value or switches to a fixed default.

Top module: `slot_ctx_mgr`

## Requirements
- R1: While reset is asserted and after it is released, each output lane shows its default value (with default parameters, lanes 0..3 show 0x0F, 0xF0, 0x5C, 0xA3), the restore bus shows the state default (0xC0DE), and the load-valid pulse is low.
- R2: A save strobe sampled at a clock edge while `present_i` is high copies `mod_state_i` into the shadow register. The copied value appears on `rst_state_o` after that edge.
- R3: A save strobe sampled while `present_i` is low is ignored. `rst_state_o` keeps its previous value no matter what `mod_state_i` carries.
- R4: A rising edge on `restore_i` produces `rst_load_o` high for exactly the one cycle that follows the sampling edge. Holding `restore_i` high produces no further pulse, and each later rising edge produces a new pulse.
- R5: During the load pulse, `rst_state_o` carries the shadow contents. If no save has been taken since reset, this is the state default.
- R6: While `present_i` is high at a clock edge, every lane takes the matching `mod_out_i` field (lane i at bits [i*OUT_W +: OUT_W]) and shows it after that edge.
- R7: A lane whose `FORCE_MASK` bit is 0 (lanes 0 and 2 by default) keeps its last passed value for as long as `present_i` is low.
- R8: A lane whose `FORCE_MASK` bit is 1 (lanes 1 and 3 by default) shows its default value from the first clock edge at which `present_i` is sampled low, for as long as it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| present_i | input | 1 | High while a complete module occupies the slot |
| save_i | input | 1 | Request to copy the module's state word |
| restore_i | input | 1 | Request to hand the saved word back (edge detected) |
| mod_state_i | input | STATE_W | Marked state signals from the module |
| mod_out_i | input | N_OUT*OUT_W | Module outputs, one OUT_W field per lane |
| rst_state_o | output | STATE_W | Saved state word toward the module |
| rst_load_o | output | 1 | One-cycle load-valid pulse for the saved word |
| slot_out_o | output | N_OUT*OUT_W | Held or defaulted slot outputs |

## Verification
Every result of this block is one register stage away from its stimulus. A lane reflects `mod_out_i` and `present_i` one edge after they are sampled, a saved word shows on the restore bus one edge after the strobe, and the load pulse is high for the cycle that follows the edge sampling the rising restore. The bench changes inputs on the falling clock edge, lets exactly one rising edge pass, and samples at the next falling edge. It then samples again after further edges to confirm that the pulse has ended and that frozen or defaulted lanes stay put while the module inputs keep changing.

// File: rtl/slot_ctx_pkg.sv
package slot_ctx_pkg;
   typedef enum logic {
      LANE_HOLD  = 1'b0,
      LANE_FORCE = 1'b1
   } lane_mode_e;

   function automatic lane_mode_e lane_mode(input logic mask_bit);
      return mask_bit ? LANE_FORCE : LANE_HOLD;
   endfunction
endpackage

// File: rtl/ctx_shadow.sv
module ctx_shadow #(
   parameter int              STATE_W   = 16,
   parameter logic [STATE_W-1:0] STATE_DEF = '0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               present_i,
   input  logic               save_i,
   input  logic               restore_i,
   input  logic [STATE_W-1:0] state_i,
   output logic [STATE_W-1:0] state_o,
   output logic               load_o
);
   logic [STATE_W-1:0] shadow_q;
   logic               restore_q;
   logic               load_q;
   logic               take_save;

   assign take_save = save_i & present_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow_q <= STATE_DEF;
      end else if (take_save) begin
         shadow_q <= state_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         restore_q <= 1'b0;
         load_q    <= 1'b0;
      end else begin
         restore_q <= restore_i;
         load_q    <= restore_i & ~restore_q;
      end
   end

   assign state_o = shadow_q;
   assign load_o  = load_q;

   // R2: a save taken while present lands in the shadow
   p_save_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (save_i && present_i) |=> (state_o == $past(state_i)));
   // R3: nothing changes the shadow while the slot is empty
   p_save_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!present_i) |=> $stable(state_o));
   // R4: the load pulse never lasts two cycles
   p_load_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      load_o |=> !load_o);
   // R4: a pulse is always preceded by a sampled restore request
   p_load_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(load_o) |-> $past(restore_i));
endmodule

// File: rtl/out_hold_lane.sv
module out_hold_lane #(
   parameter int           W     = 8,
   parameter logic         FORCE = 1'b0,
   parameter logic [W-1:0] DEF   = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         present_i,
   input  logic [W-1:0] lane_i,
   output logic [W-1:0] lane_o
);
   import slot_ctx_pkg::*;

   localparam lane_mode_e MODE = lane_mode(FORCE);

   logic [W-1:0] lane_q;

   generate
      if (MODE == LANE_FORCE) begin : g_force
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lane_q <= DEF;
            end else begin
               lane_q <= present_i ? lane_i : DEF;
            end
         end
         // R8: an empty slot drives the lane default
         p_force_default_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (!present_i) |=> (lane_o == DEF));
      end else begin : g_hold
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lane_q <= DEF;
            end else if (present_i) begin
               lane_q <= lane_i;
            end
         end
         // R7: an empty slot freezes the lane
         p_hold_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (!present_i) |=> $stable(lane_o));
      end
   endgenerate

   assign lane_o = lane_q;

   // R6: a present module is passed through one edge later
   p_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      present_i |=> (lane_o == $past(lane_i)));
endmodule

// File: rtl/slot_ctx_mgr.sv
module slot_ctx_mgr #(
   parameter int                       STATE_W     = 16,
   parameter int                       N_OUT       = 4,
   parameter int                       OUT_W       = 8,
   parameter logic [N_OUT-1:0]         FORCE_MASK  = 4'b1010,
   parameter logic [N_OUT*OUT_W-1:0]   OUT_DEFAULT = 32'hA35C_F00F,
   parameter logic [STATE_W-1:0]       STATE_DEF   = 16'hC0DE
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   present_i,
   input  logic                   save_i,
   input  logic                   restore_i,
   input  logic [STATE_W-1:0]     mod_state_i,
   input  logic [N_OUT*OUT_W-1:0] mod_out_i,
   output logic [STATE_W-1:0]     rst_state_o,
   output logic                   rst_load_o,
   output logic [N_OUT*OUT_W-1:0] slot_out_o
);
   localparam int BUS_W = N_OUT * OUT_W;

   generate
      if (STATE_W < 1) begin : g_bad_state_w
         $error("slot_ctx_mgr: STATE_W must be at least 1");
      end
      if (N_OUT < 1) begin : g_bad_n_out
         $error("slot_ctx_mgr: N_OUT must be at least 1");
      end
      if (OUT_W < 1) begin : g_bad_out_w
         $error("slot_ctx_mgr: OUT_W must be at least 1");
      end
   endgenerate

   ctx_shadow #(
      .STATE_W  (STATE_W),
      .STATE_DEF(STATE_DEF)
   ) i_shadow (
      .clk      (clk),
      .rst_n    (rst_n),
      .present_i(present_i),
      .save_i   (save_i),
      .restore_i(restore_i),
      .state_i  (mod_state_i),
      .state_o  (rst_state_o),
      .load_o   (rst_load_o)
   );

   logic [BUS_W-1:0] lanes_w;

   generate
      for (genvar g = 0; g < N_OUT; g++) begin : g_lane
         out_hold_lane #(
            .W    (OUT_W),
            .FORCE(FORCE_MASK[g]),
            .DEF  (OUT_DEFAULT[g*OUT_W +: OUT_W])
         ) i_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .present_i(present_i),
            .lane_i   (mod_out_i[g*OUT_W +: OUT_W]),
            .lane_o   (lanes_w[g*OUT_W +: OUT_W])
         );
      end
   endgenerate

   assign slot_out_o = lanes_w;

   // R5: during the load pulse the bus carries a stable shadow word
   p_restore_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_load_o && !save_i) |=> $stable(rst_state_o));
endmodule

// File: tb/test_slot_ctx_mgr.sv
module test_slot_ctx_mgr;
   localparam logic [31:0] DEFS  = 32'hA35C_F00F;
   localparam logic [3:0]  FMASK = 4'b1010;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        present_i = 1'b0;
   logic        save_i = 1'b0;
   logic        restore_i = 1'b0;
   logic [15:0] mod_state_i = '0;
   logic [31:0] mod_out_i = '0;
   logic [15:0] rst_state_o;
   logic        rst_load_o;
   logic [31:0] slot_out_o;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   slot_ctx_mgr i_slot_ctx_mgr (
      .clk        (clk),
      .rst_n      (rst_n),
      .present_i  (present_i),
      .save_i     (save_i),
      .restore_i  (restore_i),
      .mod_state_i(mod_state_i),
      .mod_out_i  (mod_out_i),
      .rst_state_o(rst_state_o),
      .rst_load_o (rst_load_o),
      .slot_out_o (slot_out_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   // Expected lanes when absent: hold lanes keep 'last', force lanes take their default
   function automatic logic [31:0] absent_view(input logic [31:0] last);
      logic [31:0] r;
      for (int i = 0; i < 4; i++)
         r[i*8 +: 8] = FMASK[i] ? DEFS[i*8 +: 8] : last[i*8 +: 8];
      return r;
   endfunction

   task automatic t_reset();
      chk("R1 lanes in reset", slot_out_o, DEFS);
      rst_n = 1'b1;
      tick();
      chk("R1 lanes after reset", slot_out_o, DEFS);
      chk("R1 state after reset", {16'h0, rst_state_o}, 32'h0000_C0DE);
      chk("R1 load after reset", {31'h0, rst_load_o}, 32'h0);
   endtask

   task automatic t_restore_default();
      restore_i = 1'b1;
      tick();
      chk("R5 load pulse without save", {31'h0, rst_load_o}, 32'h1);
      chk("R5 default word restored", {16'h0, rst_state_o}, 32'h0000_C0DE);
      restore_i = 1'b0;
      tick();
      chk("R4 pulse ends", {31'h0, rst_load_o}, 32'h0);
   endtask

   task automatic t_pass_and_hold();
      present_i = 1'b1;
      mod_out_i = 32'h1122_3344;
      tick();
      chk("R6 pass through", slot_out_o, 32'h1122_3344);
      mod_out_i = 32'h5566_7788;
      tick();
      chk("R6 second pattern", slot_out_o, 32'h5566_7788);
      present_i = 1'b0;
      mod_out_i = 32'h9988_7766;
      tick();
      chk("R7 R8 absent view", slot_out_o, absent_view(32'h5566_7788));
      chk("R7 hold lane0", {24'h0, slot_out_o[7:0]}, 32'h88);
      chk("R8 force lane1", {24'h0, slot_out_o[15:8]}, 32'hF0);
      mod_out_i = 32'hDEAD_BEEF;
      tick();
      tick();
      chk("R7 R8 absent stays", slot_out_o, absent_view(32'h5566_7788));
   endtask

   task automatic t_save_restore();
      present_i   = 1'b1;
      mod_state_i = 16'h1234;
      save_i      = 1'b1;
      tick();
      save_i = 1'b0;
      chk("R2 saved word", {16'h0, rst_state_o}, 32'h0000_1234);
      present_i   = 1'b0;
      mod_state_i = 16'hBEEF;
      save_i      = 1'b1;
      tick();
      save_i = 1'b0;
      chk("R3 save while absent ignored", {16'h0, rst_state_o}, 32'h0000_1234);
      restore_i = 1'b1;
      tick();
      chk("R4 pulse on rise", {31'h0, rst_load_o}, 32'h1);
      chk("R5 saved word on bus", {16'h0, rst_state_o}, 32'h0000_1234);
      tick();
      chk("R4 no pulse while held", {31'h0, rst_load_o}, 32'h0);
      tick();
      chk("R4 still no pulse", {31'h0, rst_load_o}, 32'h0);
      restore_i = 1'b0;
      tick();
      restore_i = 1'b1;
      tick();
      chk("R4 new pulse on second rise", {31'h0, rst_load_o}, 32'h1);
      restore_i = 1'b0;
      tick();
      chk("R4 second pulse ends", {31'h0, rst_load_o}, 32'h0);
   endtask

   initial begin
      #(8 * 200000);
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      @(negedge clk);
      @(negedge clk);
      t_reset();
      t_restore_default();
      t_pass_and_hold();
      t_save_restore();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule